// File: doc/BRIEF.md
# Phase-Disposition Multicarrier PWM

This block produces the switching commands for one phase of a multilevel inverter with `LEVELS` output levels. A single up/down counter forms a base triangle that ramps from 0 to `PEAK` and back. `LEVELS-1` carriers are built from it by adding a fixed band offset to each one. The carriers therefore share frequency, phase and peak-to-peak swing, and they sit stacked in adjacent amplitude bands of height `PEAK`. The full stack spans 0 to `(LEVELS-1)*PEAK`.

A signed modulating reference is shifted so that a value of zero sits at the middle of the stack. The reference is captured only when the base triangle is at its valley. Each carrier is then compared with the captured reference. A carrier's gate bit is high when the reference is strictly greater than that carrier. Because of the stacking, the gate bits always form a thermometer code. The number of bits set is reported as the selected output level.

Upstream logic drives the reference once per carrier period, and downstream logic maps levels or gate bits onto power switches. The triangle value is brought out so that a reference generator can align to the valley.

Top module: `pdpwm_top`

## Requirements
- R1: The block drives exactly `LEVELS-1` gate bits, one per carrier. Bit k belongs to the carrier in band k, and bit 0 is the lowest band.
- R2: After reset the base triangle on `ramp_o` starts at 0 and steps by exactly 1 each clock. It rises to `PEAK`, falls back to 0 and repeats, with a period of `2*PEAK` clocks.
- R3: Carrier k, for k = 0 … `LEVELS-2`, equals the base triangle plus `k*PEAK`. The bands are contiguous and share frequency, phase and swing.
- R4: The reference is centred on the stack. The value compared is `ref_i + ((LEVELS-1)*PEAK)/2`, so `ref_i = 0` sits mid-stack.
- R5: Gate bit k is 1 exactly when the centred reference is strictly greater than carrier k. A reference equal to a carrier leaves that bit at 0.
- R6: The reference is captured only on the clock edge at which `ramp_o` is 0. Changes of `ref_i` in any other cycle have no effect on the outputs until the next valley.
- R7: `level_o` equals the number of gate bits set. The gate bits are thermometer coded: a bit is never set while a lower bit is clear.
- R8: A synchronous active-high reset clears `ramp_o`, `gate_o`, `level_o` and the captured reference. The captured reference is cleared to 0, which is mid-stack.
- R9: The outputs are registered. `gate_o` and `level_o` in cycle n+1 reflect the triangle and the captured reference of cycle n. A reference below the stack gives level 0 with all gates off. A reference above the stack gives level `LEVELS-1` with all gates on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | RW | Signed modulating reference, zero at mid-stack |
| ramp_o | output | $clog2(PEAK+1) | Base triangle value; 0 marks the valley |
| gate_o | output | LEVELS-1 | One switching command per carrier, bit 0 lowest band |
| level_o | output | $clog2(LEVELS) | Selected output level, 0 … LEVELS-1 |

## Verification
Two functions meet in the valley cycle. In that cycle the comparators still evaluate the old captured reference while the register takes in the new one. The bench provokes this by changing `ref_i` on every clock, valley cycles included. Its behavioural model captures the reference on the valley edge only, and the outputs are compared against it on every clock, so an early or late capture shows up as a level mismatch. A second case is also exercised: a reference on a band boundary ties with one carrier at the valley and with the carrier below it at the peak. Both ties must leave the gate off.

// File: rtl/pdpwm_pkg.sv
package pdpwm_pkg;

  // Direction of the shared base triangle
  typedef enum logic {
    SLOPE_UP   = 1'b0,
    SLOPE_DOWN = 1'b1
  } slope_e;

  // Signed width needed to hold both the centred reference and every carrier
  function automatic int cmp_width(input int ref_w, input int car_w);
    return ((ref_w > car_w) ? ref_w : car_w) + 2;
  endfunction

endpackage

// File: rtl/pdpwm_ramp.sv
module pdpwm_ramp
  import pdpwm_pkg::*;
#(
  parameter int PEAK = 16,
  parameter int TW   = $clog2(PEAK + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] ramp_o,
  output logic          valley_o
);

  logic [TW-1:0] ramp_q;
  slope_e        slope_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_q  <= '0;
      slope_q <= SLOPE_UP;
    end else begin
      case (slope_q)
        SLOPE_UP: begin
          ramp_q <= ramp_q + TW'(1);
          if (ramp_q == TW'(PEAK - 1)) slope_q <= SLOPE_DOWN;
        end
        default: begin
          ramp_q <= ramp_q - TW'(1);
          if (ramp_q == TW'(1)) slope_q <= SLOPE_UP;
        end
      endcase
    end
  end

  assign ramp_o   = ramp_q;
  assign valley_o = (ramp_q == '0);

  // R2
  ramp_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(ramp_q) <= PEAK);

  // R2
  ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((int'(ramp_q) == int'($past(ramp_q)) + 1) ||
              (int'(ramp_q) == int'($past(ramp_q)) - 1)));

  // R2
  ramp_peak_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(ramp_q) == PEAK) |=> (int'(ramp_q) == PEAK - 1));

  // R2
  ramp_valley_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (ramp_q == '0) |=> (ramp_q == TW'(1)));

endmodule

// File: rtl/pdpwm_ref_hold.sv
module pdpwm_ref_hold #(
  parameter int RW  = 8,
  parameter int SW  = 10,
  parameter int MID = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valley_i,
  input  logic signed [RW-1:0] ref_i,
  output logic signed [SW-1:0] ref_c_o
);

  logic signed [RW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)           hold_q <= '0;
    else if (valley_i) hold_q <= ref_i;
  end

  // Shift the signed reference so that zero lands in the middle of the stack
  assign ref_c_o = SW'(hold_q) + SW'(MID);

  // R6
  ref_capture_chk: assert property (@(posedge clk) disable iff (rst)
    valley_i |=> (hold_q == $past(ref_i)));

  // R6
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valley_i |=> $stable(hold_q));

endmodule

// File: rtl/pdpwm_cmp_bank.sv
module pdpwm_cmp_bank #(
  parameter int NCAR = 4,
  parameter int PEAK = 16,
  parameter int TW   = 5,
  parameter int SW   = 10
) (
  input  logic [TW-1:0]        ramp_i,
  input  logic signed [SW-1:0] ref_c_i,
  output logic [NCAR-1:0]      therm_o
);

  for (genvar k = 0; k < NCAR; k++) begin : g_band
    logic signed [SW-1:0] carrier;
    // Same triangle, lifted by k band heights
    assign carrier    = $signed(SW'(ramp_i)) + $signed(SW'(k * PEAK));
    // Strictly greater: a tie leaves the device off
    assign therm_o[k] = (ref_c_i > carrier);
  end

endmodule

// File: rtl/pdpwm_lvl_enc.sv
module pdpwm_lvl_enc #(
  parameter int NCAR = 4,
  parameter int LW   = 3
) (
  input  logic [NCAR-1:0] therm_i,
  output logic [LW-1:0]   level_o
);

  always_comb begin
    level_o = '0;
    for (int k = 0; k < NCAR; k++) begin
      level_o = level_o + LW'(therm_i[k]);
    end
  end

endmodule

// File: rtl/pdpwm_top.sv
module pdpwm_top
  import pdpwm_pkg::*;
#(
  parameter int LEVELS = 5,
  parameter int PEAK   = 16,
  parameter int RW     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic signed [RW-1:0]         ref_i,
  output logic [$clog2(PEAK+1)-1:0]    ramp_o,
  output logic [LEVELS-2:0]            gate_o,
  output logic [$clog2(LEVELS)-1:0]    level_o
);

  localparam int NCAR = LEVELS - 1;
  localparam int TW   = $clog2(PEAK + 1);
  localparam int LW   = $clog2(LEVELS);
  localparam int TOP  = NCAR * PEAK;
  localparam int MID  = TOP / 2;
  localparam int CARW = $clog2(TOP + 1);
  localparam int SW   = cmp_width(RW, CARW);

  logic                 valley;
  logic [TW-1:0]        ramp;
  logic signed [SW-1:0] ref_c;
  logic [NCAR-1:0]      therm;
  logic [LW-1:0]        level_n;
  logic [NCAR-1:0]      gate_q;
  logic [LW-1:0]        level_q;

  pdpwm_ramp #(.PEAK(PEAK), .TW(TW)) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .ramp_o   (ramp),
    .valley_o (valley)
  );

  pdpwm_ref_hold #(.RW(RW), .SW(SW), .MID(MID)) u_ref (
    .clk      (clk),
    .rst      (rst),
    .valley_i (valley),
    .ref_i    (ref_i),
    .ref_c_o  (ref_c)
  );

  pdpwm_cmp_bank #(.NCAR(NCAR), .PEAK(PEAK), .TW(TW), .SW(SW)) u_cmp (
    .ramp_i  (ramp),
    .ref_c_i (ref_c),
    .therm_o (therm)
  );

  pdpwm_lvl_enc #(.NCAR(NCAR), .LW(LW)) u_enc (
    .therm_i (therm),
    .level_o (level_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= '0;
      level_q <= '0;
    end else begin
      gate_q  <= therm;
      level_q <= level_n;
    end
  end

  assign ramp_o  = ramp;
  assign gate_o  = gate_q;
  assign level_o = level_q;

  // R7
  therm_mono_chk: assert property (@(posedge clk) disable iff (rst)
    ((gate_q >> 1) & ~gate_q) == '0);

  // R7
  level_count_chk: assert property (@(posedge clk) disable iff (rst)
    int'(level_q) == $countones(gate_q));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (gate_q == '0 && level_q == '0 && ramp == '0));

  // R9
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(level_q) <= NCAR);

endmodule

// File: tb/pdpwm_top_test.sv
module pdpwm_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int LEVELS = 5;
  localparam int PEAK   = 16;
  localparam int RW     = 8;
  localparam int NCAR   = LEVELS - 1;
  localparam int MID    = (NCAR * PEAK) / 2;

  logic                          clk = 1'b0;
  logic                          rst = 1'b1;
  logic signed [RW-1:0]          ref_in = '0;
  logic [$clog2(PEAK+1)-1:0]     ramp;
  logic [NCAR-1:0]               gate;
  logic [$clog2(LEVELS)-1:0]     level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural model state
  int m_ramp = 0;
  int m_dir  = 1;
  int m_ref  = 0;
  int exp_gate = 0;
  int exp_level = 0;
  string cur_req = "R3";
  string tag_q = "R3";

  pdpwm_top #(.LEVELS(LEVELS), .PEAK(PEAK), .RW(RW)) uut (
    .clk     (clk),
    .rst     (rst),
    .ref_i   (ref_in),
    .ramp_o  (ramp),
    .gate_o  (gate),
    .level_o (level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model, advanced on every rising edge from its own state
  always @(posedge clk) begin
    if (rst) begin
      exp_gate  = 0;
      exp_level = 0;
      m_ramp = 0;
      m_dir  = 1;
      m_ref  = 0;
    end else begin
      exp_gate  = 0;
      exp_level = 0;
      for (int k = 0; k < NCAR; k++) begin
        if (m_ref + MID > m_ramp + k * PEAK) begin
          exp_gate = exp_gate | (1 << k);
          exp_level++;
        end
      end
      if (m_ramp == 0) m_ref = int'(ref_in);
      m_ramp = m_ramp + m_dir;
      if (m_ramp == PEAK) m_dir = -1;
      if (m_ramp == 0)    m_dir = 1;
    end
    tag_q = cur_req;
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2", "ramp", int'(ramp), m_ramp);
      chk(tag_q, "gate", int'(gate), exp_gate);
      chk("R7", "level", int'(level), exp_level);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R8: reset state
    step(3);
    chk("R8", "ramp in reset", int'(ramp), 0);
    chk("R8", "gate in reset", int'(gate), 0);
    chk("R8", "level in reset", int'(level), 0);
    rst = 1'b0;

    // R4: zero reference sits mid-stack
    cur_req = "R4";
    ref_in = '0;
    step(3 * 2 * PEAK);

    // R3: slow sweep through every band
    cur_req = "R3";
    for (int v = -40; v <= 40; v++) begin
      ref_in = RW'(v);
      step(2);
    end

    // R6: reference changes every cycle, valleys included
    cur_req = "R6";
    for (int i = 0; i < 8 * PEAK; i++) begin
      ref_in = RW'(int'($urandom_range(255)) - 128);
      step(1);
    end

    // R5: references on band boundaries tie with carriers
    cur_req = "R5";
    for (int j = -2; j <= 2; j++) begin
      ref_in = RW'(j * PEAK);
      step(2 * PEAK);
    end

    // R9: saturation above and below the stack
    cur_req = "R9";
    ref_in = RW'(127);
    step(4 * PEAK);
    chk("R1", "all gates above stack", int'(gate), (1 << NCAR) - 1);
    chk("R9", "top level", int'(level), LEVELS - 1);
    ref_in = RW'(-128);
    step(4 * PEAK);
    chk("R9", "gates below stack", int'(gate), 0);
    chk("R9", "bottom level", int'(level), 0);

    // R8: reset in mid-run
    ref_in = RW'(50);
    step(5);
    rst = 1'b1;
    step(2);
    chk("R8", "ramp after reset", int'(ramp), 0);
    chk("R8", "gate after reset", int'(gate), 0);
    chk("R8", "level after reset", int'(level), 0);
    rst = 1'b0;
    cur_req = "R6";
    step(3 * PEAK);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule